// File: doc/BRIEF.md
# Split Program Counter with Deferred Page Carry

This block holds a processor's program counter as two byte-wide halves, a low byte and a high byte. Each half has its own 4-bit gate command, which a cycle sequencer outside the block drives every cycle. The command has two ports. The front port carries data: it loads the half from the internal data bus, or it drives the half onto a data output, for example to push a return address. The back port carries addresses: it drives the half onto the address output, and it steps the half when the write enable is also asserted.

A normal fetch steps only the low byte. When the low byte wraps from its top value to zero, the block does not carry into the high byte in the same cycle. It raises a page-carry flag instead, so that the sequencer can insert an extra page cycle. During that page cycle the high byte steps and the low byte holds, and the flag drops after the page cycle. Vector and jump targets arrive over the data bus one byte per cycle, low byte first.

Top module: `split_pc`

## Requirements
- R1: While `rstN` is low and after it is released, both halves are zero and `pageCarry` is 0 until a command changes them.
- R2: Command bits are active low. Bit 3 is the front output enable, bit 2 the front write enable, bit 1 the back output enable and bit 0 the back write enable. A back write enable without a back output enable does not step the low byte.
- R3: When the low command has both back enables asserted (4'b1100), no front write is asserted and `pageCarry` is 0, the low byte increments at the next clock edge. If the high command asserts neither its back enables nor its front write, the high byte does not change.
- R4: A low-byte increment from the all-ones value to zero sets `pageCarry` to 1 for exactly the following cycle.
- R5: In a cycle with `pageCarry` = 1, the high byte increments at the clock edge and the low byte holds, even if a fetch command is present. `pageCarry` is 0 after that edge.
- R6: A front write enable loads the half from `dataIn` at the clock edge. This load has priority over any increment of the same half, and a load of the low byte never raises `pageCarry`.
- R7: A front write of the high byte during a page cycle loads `dataIn` instead of incrementing. `pageCarry` still clears.
- R8: A high command with both back enables asserted increments the high byte by exactly one at the clock edge. This also holds when it coincides with a page cycle.
- R9: `frontOut` shows the high byte when the high front output enable is asserted, otherwise the low byte when the low front output enable is asserted, otherwise zero.
- R10: The high byte of `addrOut` shows the high byte of the counter while the high back output enable is asserted, and zero otherwise. The low byte of `addrOut` follows the low back output enable in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| loCmd | input | 4 | Gate command for the low byte, active low |
| hiCmd | input | 4 | Gate command for the high byte, active low |
| dataIn | input | 8 | Internal data bus, source for loads |
| pcOut | output | 16 | Current counter value, {high, low} |
| frontOut | output | 8 | Front-port data output |
| addrOut | output | 16 | Back-port address output |
| pageCarry | output | 1 | Page-carry indication for the sequencer |

## Verification
The bench targets the low-byte wrap. A design that carries into the high byte at once would show the wrong high byte one cycle early. A design that keeps stepping the low byte during the page cycle would skip an address. A design that leaves the flag high would step the high byte twice. The bench also loads the low byte with the all-ones value while a fetch is pending, and loads the high byte during a page cycle, to expose a wrong priority between load and increment. It walks several hundred fetches across page boundaries so that every wrap is compared against the reference model.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int CMD_W   = 4;
  localparam int CMD_FOE = 3;
  localparam int CMD_FWE = 2;
  localparam int CMD_BOE = 1;
  localparam int CMD_BWE = 0;

  typedef struct packed {
    logic loLoad;
    logic hiLoad;
    logic loInc;
    logic hiInc;
    logic loFrontOe;
    logic hiFrontOe;
    logic loBackOe;
    logic hiBackOe;
  } pcStrobe_t;
endpackage

// File: rtl/pcs_ctrl.sv
module pcs_ctrl
  import pcs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [CMD_W-1:0] loCmd,
  input  logic [CMD_W-1:0] hiCmd,
  input  logic             loAtTop,
  output pcStrobe_t        stb,
  output logic             pageCarry
);
  logic carryQ;
  logic loStep;
  logic hiStep;

  // commands are active low
  assign loStep = ~loCmd[CMD_BOE] & ~loCmd[CMD_BWE];
  assign hiStep = ~hiCmd[CMD_BOE] & ~hiCmd[CMD_BWE];

  always_comb begin
    stb.loLoad    = ~loCmd[CMD_FWE];
    stb.hiLoad    = ~hiCmd[CMD_FWE];
    stb.loInc     = loStep & loCmd[CMD_FWE] & ~carryQ;
    stb.hiInc     = (carryQ | hiStep) & hiCmd[CMD_FWE];
    stb.loFrontOe = ~loCmd[CMD_FOE];
    stb.hiFrontOe = ~hiCmd[CMD_FOE];
    stb.loBackOe  = ~loCmd[CMD_BOE];
    stb.hiBackOe  = ~hiCmd[CMD_BOE];
  end

  // deferred carry: set on a low wrap, lives for one page cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) carryQ <= 1'b0;
    else       carryQ <= stb.loInc & loAtTop;
  end

  assign pageCarry = carryQ;
endmodule

// File: rtl/pcs_dpath.sv
module pcs_dpath
  import pcs_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  pcStrobe_t           stb,
  input  logic [BYTE_W-1:0]   dataIn,
  output logic [2*BYTE_W-1:0] pcVal,
  output logic [BYTE_W-1:0]   frontOut,
  output logic [2*BYTE_W-1:0] addrOut,
  output logic                loAtTop
);
  localparam int HALVES = 2;

  logic [BYTE_W-1:0] half   [HALVES];
  logic [HALVES-1:0] ldVec;
  logic [HALVES-1:0] incVec;
  logic [HALVES-1:0] boeVec;

  assign ldVec  = {stb.hiLoad, stb.loLoad};
  assign incVec = {stb.hiInc, stb.loInc};
  assign boeVec = {stb.hiBackOe, stb.loBackOe};

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          half[h] <= '0;
      else if (ldVec[h])  half[h] <= dataIn;
      else if (incVec[h]) half[h] <= half[h] + 1'b1;
    end
    assign pcVal[h*BYTE_W +: BYTE_W]   = half[h];
    assign addrOut[h*BYTE_W +: BYTE_W] = boeVec[h] ? half[h] : '0;
  end

  assign loAtTop = &half[0];

  always_comb begin
    if (stb.hiFrontOe)      frontOut = half[1];
    else if (stb.loFrontOe) frontOut = half[0];
    else                    frontOut = '0;
  end
endmodule

// File: rtl/split_pc.sv
module split_pc
  import pcs_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CMD_W-1:0]    loCmd,
  input  logic [CMD_W-1:0]    hiCmd,
  input  logic [BYTE_W-1:0]   dataIn,
  output logic [2*BYTE_W-1:0] pcOut,
  output logic [BYTE_W-1:0]   frontOut,
  output logic [2*BYTE_W-1:0] addrOut,
  output logic                pageCarry
);
  pcStrobe_t stb;
  logic      loAtTop;

  pcs_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .loCmd(loCmd), .hiCmd(hiCmd),
    .loAtTop(loAtTop), .stb(stb), .pageCarry(pageCarry)
  );

  pcs_dpath #(.BYTE_W(BYTE_W)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .dataIn(dataIn),
    .pcVal(pcOut), .frontOut(frontOut), .addrOut(addrOut), .loAtTop(loAtTop)
  );
endmodule

// File: rtl/split_pc_chk.sv
module split_pc_chk #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [3:0]          loCmd,
  input logic [3:0]          hiCmd,
  input logic [BYTE_W-1:0]   dataIn,
  input logic [2*BYTE_W-1:0] pcOut,
  input logic [BYTE_W-1:0]   frontOut,
  input logic [2*BYTE_W-1:0] addrOut,
  input logic                pageCarry
);
  AST_CARRY_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (loCmd == 4'b1100 && !pageCarry && &pcOut[BYTE_W-1:0]) |=> pageCarry); // R4

  AST_CARRY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    pageCarry |=> !pageCarry); // R5

  AST_LO_HOLD_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    (pageCarry && loCmd[2]) |=> pcOut[BYTE_W-1:0] == $past(pcOut[BYTE_W-1:0])); // R5

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    !loCmd[2] |=> pcOut[BYTE_W-1:0] == $past(dataIn)); // R6

  AST_HI_STABLE_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    (!pageCarry && hiCmd[2] && (hiCmd[1] || hiCmd[0]))
      |=> pcOut[2*BYTE_W-1:BYTE_W] == $past(pcOut[2*BYTE_W-1:BYTE_W])); // R3

  AST_FRONT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (loCmd[3] && hiCmd[3]) |-> frontOut == '0); // R9
endmodule

bind split_pc split_pc_chk #(.BYTE_W(BYTE_W)) chk_i (
  .clk(clk), .rstN(rstN), .loCmd(loCmd), .hiCmd(hiCmd), .dataIn(dataIn),
  .pcOut(pcOut), .frontOut(frontOut), .addrOut(addrOut), .pageCarry(pageCarry)
);

// File: tb/split_pc_tb_top.sv
`timescale 1ns/1ps
module split_pc_tb_top;
  // R2: active-low command encodings used below
  localparam logic [3:0] IDLE  = 4'b1111;
  localparam logic [3:0] FETCH = 4'b1100;
  localparam logic [3:0] FWE   = 4'b1011;
  localparam logic [3:0] FOE   = 4'b0111;
  localparam logic [3:0] BOE   = 4'b1101;
  localparam logic [3:0] BWE   = 4'b1110;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  loCmd = IDLE;
  logic [3:0]  hiCmd = IDLE;
  logic [7:0]  dataIn = '0;
  logic [15:0] pcOut;
  logic [7:0]  frontOut;
  logic [15:0] addrOut;
  logic        pageCarry;

  int errors = 0;
  int checks = 0;
  int refLo = 0, refHi = 0, refCarry = 0;

  always #2.5 clk = ~clk;

  split_pc dut_i (
    .clk(clk), .rstN(rstN), .loCmd(loCmd), .hiCmd(hiCmd), .dataIn(dataIn),
    .pcOut(pcOut), .frontOut(frontOut), .addrOut(addrOut), .pageCarry(pageCarry)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: drive after a falling edge, check outputs, clock, check state
  task automatic step(input logic [3:0] lc, input logic [3:0] hc,
                      input logic [7:0] d, input string tag);
    int expFront, nLo, nHi, nCarry;
    bit loInc, hiInc;
    @(negedge clk);
    loCmd = lc; hiCmd = hc; dataIn = d;
    #1;
    expFront = !hc[3] ? refHi : (!lc[3] ? refLo : 0);
    chk("R9 frontOut", frontOut, expFront);
    chk("R10 addrOut", addrOut, ((!hc[1] ? refHi : 0) << 8) | (!lc[1] ? refLo : 0));
    loInc  = !lc[1] && !lc[0] && lc[2] && (refCarry == 0);
    hiInc  = (refCarry != 0) || (!hc[1] && !hc[0]);
    nCarry = (loInc && refLo == 255) ? 1 : 0;
    nLo = !lc[2] ? int'(d) : (loInc ? (refLo + 1) % 256 : refLo);
    nHi = !hc[2] ? int'(d) : (hiInc ? (refHi + 1) % 256 : refHi);
    refLo = nLo; refHi = nHi; refCarry = nCarry;
    @(posedge clk);
    #1;
    chk({tag, " pcOut"}, pcOut, (refHi << 8) | refLo);
    chk({tag, " pageCarry"}, int'(pageCarry), refCarry);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    #12;
    chk("R1 pcOut in reset", pcOut, 0);
    chk("R1 pageCarry in reset", int'(pageCarry), 0);
    @(negedge clk); rstN = 1'b1;
    step(IDLE, IDLE, 8'h55, "R1");
    // vector load, low first then high
    step(FWE, IDLE, 8'hFD, "R6");
    step(IDLE, FWE, 8'h12, "R6");
    step(FETCH, IDLE, 8'h00, "R3");
    step(FETCH, IDLE, 8'h00, "R3");
    step(FETCH, IDLE, 8'h00, "R4");   // FF -> 00, carry raised
    step(FETCH, IDLE, 8'h00, "R5");   // page cycle: hi steps, lo holds
    step(FETCH, IDLE, 8'h00, "R5");
    step(BWE, IDLE, 8'h00, "R2");     // back write alone: no step
    step(4'b1000, IDLE, 8'hFF, "R6"); // load beats fetch, no carry
    step(FETCH, IDLE, 8'h00, "R4");
    step(IDLE, FWE, 8'h40, "R7");     // load during page cycle
    step(IDLE, FETCH, 8'h00, "R8");
    step(FOE, FOE, 8'h00, "R9");
    step(FOE, IDLE, 8'h00, "R9");
    step(BOE, BOE, 8'h00, "R10");
    step(BOE, IDLE, 8'h00, "R10");
    // explicit hi step coinciding with a page cycle
    step(4'b1000, IDLE, 8'hFF, "R6");
    step(FETCH, IDLE, 8'h00, "R4");
    step(IDLE, FETCH, 8'h00, "R8");
    // long fetch walk across several pages
    for (int i = 0; i < 700; i++) begin
      step(FETCH, (i % 3 == 0) ? BOE : IDLE, 8'(i), "R4");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule